// File: doc/BRIEF.md
# Word Multiply-Accumulate With Saturation

This block multiplies two signed 16-bit operands into a signed 32-bit product and adds that product into an accumulator kept as a high half and a low half, each 32 bits wide. A mode input selects between two kinds of accumulation. In wrapping mode, the two halves form one 64-bit signed value, and the sign-extended product is added to all of it.

In saturating mode, only the low half takes part in the sum, as a signed 32-bit value. If the result overflows, the low half is clamped to the nearest signed 32-bit limit, and bit 0 of the high half records that an overflow happened.

The operands arrive already fetched, and a one-cycle start strobe commits one accumulation at the next clock edge. Each half has its own load port, so that clearing or initialising the accumulator is a plain write.

Top module: `mac_sat_acc`

## Requirements
- R1: A synchronous active-low reset sets both accumulator halves to zero at the clock edge where reset is low, even if start or a load is also asserted.
- R2: Both operands are read as two's-complement 16-bit values, and the product is the exact signed 32-bit result; for example, -32768 times -32768 gives 0x40000000.
- R3: When the mode bit is 0 and start is high, {high, low} becomes {high, low} plus the product sign-extended to 64 bits, with carries and borrows passing between the halves.
- R4: When the mode bit is 1 and start is high, the low half becomes its signed 32-bit value plus the product if the exact sum lies in [-2^31, 2^31-1]; with no overflow, the high half keeps its value.
- R5: In mode 1, a sum above 2^31-1 writes 0x7FFFFFFF to the low half and sets bit 0 of the high half.
- R6: In mode 1, a sum below -2^31 writes 0x80000000 to the low half and sets bit 0 of the high half.
- R7: In mode 1, an accumulation never changes bits 31..1 of the high half and never clears bit 0 of the high half.
- R8: While start is low and no load is asserted, both halves hold their values; the operands and the mode bit have no effect.
- R9: A load enable writes its data into its own half at the next edge, taking precedence over accumulation for that half only; the other half still takes its accumulation result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Commit one accumulation at this edge |
| op_a_i | input | 16 | First signed operand |
| op_b_i | input | 16 | Second signed operand |
| sat_mode_i | input | 1 | 1 selects saturating 32-bit mode, 0 selects 64-bit wrapping mode |
| hi_load_en_i | input | 1 | Write hi_load_data_i into the high half |
| hi_load_data_i | input | 32 | Load value for the high half |
| lo_load_en_i | input | 1 | Write lo_load_data_i into the low half |
| lo_load_data_i | input | 32 | Load value for the low half |
| acc_hi_o | output | 32 | High half of the accumulator |
| acc_lo_o | output | 32 | Low half of the accumulator |

## Verification
The bench builds the block with its default widths: 16-bit operands and 32-bit halves. With these widths the product range is large enough to reach both saturation limits from preloaded low halves, and to produce a carry or borrow across the 32-bit boundary in wrapping mode. The cases include sums landing exactly on 0x7FFFFFFF and 0x80000000, an overflow when the flag bit is already set, and a load of one half in the same cycle as an accumulation.

// File: rtl/mac_pkg.sv
// Shared types for the multiply-accumulate block.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package mac_pkg;

    // Source that updates one accumulator half at a clock edge.
    typedef enum logic [1:0] {
        HALF_HOLD = 2'd0,
        HALF_LOAD = 2'd1,
        HALF_ACC  = 2'd2
    } half_src_e;

    // Picks the update source; a load always beats an accumulation.
    function automatic half_src_e pick_src(input logic load_en, input logic acc_en);
        if (load_en)     return HALF_LOAD;
        else if (acc_en) return HALF_ACC;
        else             return HALF_HOLD;
    endfunction

endpackage

// File: rtl/mac_mult.sv
// Signed multiplier: a two's-complement OP_W x OP_W product, exact in 2*OP_W bits.
// Assumes: both operands are signed; purely combinational.
module mac_mult #(
    parameter int OP_W = 16,
    localparam int PROD_W = 2 * OP_W
) (
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    output logic [PROD_W-1:0] prod
);
    logic signed [PROD_W-1:0] prod_s;

    // Form the signed product at full width.
    always_comb begin
        prod_s = PROD_W'($signed(op_a)) * PROD_W'($signed(op_b));
        prod   = prod_s;
    end
endmodule

// File: rtl/mac_wide_add.sv
// Wrapping accumulator adder: adds the sign-extended product to {hi, lo}.
// Assumes: HALF_W >= PROD_W; the result wraps modulo 2^(2*HALF_W).
module mac_wide_add #(
    parameter int PROD_W = 32,
    parameter int HALF_W = 32,
    localparam int ACC_W = 2 * HALF_W
) (
    input  logic [HALF_W-1:0] acc_hi,
    input  logic [HALF_W-1:0] acc_lo,
    input  logic [PROD_W-1:0] prod,
    output logic [HALF_W-1:0] sum_hi,
    output logic [HALF_W-1:0] sum_lo
);
    logic [ACC_W-1:0] prod_ext;
    logic [ACC_W-1:0] sum;

    // Sign-extend the product and add it across both halves.
    always_comb begin
        prod_ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
        sum      = {acc_hi, acc_lo} + prod_ext;
        sum_hi   = sum[ACC_W-1:HALF_W];
        sum_lo   = sum[HALF_W-1:0];
    end
endmodule

// File: rtl/mac_sat_add.sv
// Saturating adder: adds the product to the low half as a signed value and clamps on overflow.
// On overflow, bit 0 of the high half is set; every other high bit passes through unchanged.
// Assumes: HALF_W >= PROD_W and HALF_W >= 2.
module mac_sat_add #(
    parameter int PROD_W = 32,
    parameter int HALF_W = 32,
    localparam int SUM_W = HALF_W + 1
) (
    input  logic [HALF_W-1:0] acc_hi,
    input  logic [HALF_W-1:0] acc_lo,
    input  logic [PROD_W-1:0] prod,
    output logic [HALF_W-1:0] res_hi,
    output logic [HALF_W-1:0] res_lo
);
    localparam logic [HALF_W-1:0] POS_LIMIT = {1'b0, {(HALF_W-1){1'b1}}};
    localparam logic [HALF_W-1:0] NEG_LIMIT = {1'b1, {(HALF_W-1){1'b0}}};

    logic [SUM_W-1:0] sum;
    logic             ovf;

    // Exact sum at one extra bit; overflow shows as disagreement of the top two bits.
    always_comb begin
        sum = {acc_lo[HALF_W-1], acc_lo} + {{(SUM_W-PROD_W){prod[PROD_W-1]}}, prod};
        ovf = sum[SUM_W-1] ^ sum[SUM_W-2];
    end

    // Clamp toward the side given by the true sign, and raise the flag bit.
    always_comb begin
        if (!ovf)                res_lo = sum[HALF_W-1:0];
        else if (sum[SUM_W-1])   res_lo = NEG_LIMIT;
        else                     res_lo = POS_LIMIT;
        res_hi = {acc_hi[HALF_W-1:1], acc_hi[0] | ovf};
    end
endmodule

// File: rtl/mac_half_reg.sv
// One accumulator half: a register with synchronous active-low reset, a load port and an accumulate port.
// Assumes: a load has priority over an accumulation in the same cycle.
module mac_half_reg
    import mac_pkg::*;
#(
    parameter int HALF_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [HALF_W-1:0] load_data,
    input  logic              acc_en,
    input  logic [HALF_W-1:0] acc_data,
    output logic [HALF_W-1:0] q
);
    half_src_e src;

    // Decide which source updates this half.
    always_comb src = pick_src(load_en, acc_en);

    // Register update with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            case (src)
                HALF_LOAD: q <= load_data;
                HALF_ACC:  q <= acc_data;
                default:   q <= q;
            endcase
        end
    end
endmodule

// File: rtl/mac_sat_acc.sv
// Multiply-accumulate top: signed OP_W x OP_W product, added into a two-half accumulator.
// sat_mode_i = 0: 2*HALF_W-bit wrapping accumulate; sat_mode_i = 1: saturating low-half accumulate.
// Assumes: operands are stable in the cycle start_i is high; the result appears after that edge.
module mac_sat_acc #(
    parameter int OP_W   = 16,
    parameter int HALF_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [OP_W-1:0]   op_a_i,
    input  logic [OP_W-1:0]   op_b_i,
    input  logic              sat_mode_i,
    input  logic              hi_load_en_i,
    input  logic [HALF_W-1:0] hi_load_data_i,
    input  logic              lo_load_en_i,
    input  logic [HALF_W-1:0] lo_load_data_i,
    output logic [HALF_W-1:0] acc_hi_o,
    output logic [HALF_W-1:0] acc_lo_o
);
    localparam int PROD_W = 2 * OP_W;
    localparam int NHALF  = 2;

    logic [PROD_W-1:0] prod;
    logic [HALF_W-1:0] wide_hi, wide_lo, sat_hi, sat_lo;
    logic [HALF_W-1:0] nxt [NHALF];
    logic [HALF_W-1:0] cur [NHALF];
    logic              ld_en [NHALF];
    logic [HALF_W-1:0] ld_dat [NHALF];

    mac_mult #(.OP_W(OP_W)) u_mult (
        .op_a (op_a_i),
        .op_b (op_b_i),
        .prod (prod)
    );

    mac_wide_add #(.PROD_W(PROD_W), .HALF_W(HALF_W)) u_wide (
        .acc_hi (cur[1]),
        .acc_lo (cur[0]),
        .prod   (prod),
        .sum_hi (wide_hi),
        .sum_lo (wide_lo)
    );

    mac_sat_add #(.PROD_W(PROD_W), .HALF_W(HALF_W)) u_sat (
        .acc_hi (cur[1]),
        .acc_lo (cur[0]),
        .prod   (prod),
        .res_hi (sat_hi),
        .res_lo (sat_lo)
    );

    // Select the accumulate result per half by mode and route the load ports.
    always_comb begin
        nxt[0]    = sat_mode_i ? sat_lo : wide_lo;
        nxt[1]    = sat_mode_i ? sat_hi : wide_hi;
        ld_en[0]  = lo_load_en_i;
        ld_en[1]  = hi_load_en_i;
        ld_dat[0] = lo_load_data_i;
        ld_dat[1] = hi_load_data_i;
    end

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        mac_half_reg #(.HALF_W(HALF_W)) u_reg (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_en   (ld_en[h]),
            .load_data (ld_dat[h]),
            .acc_en    (start_i),
            .acc_data  (nxt[h]),
            .q         (cur[h])
        );
    end

    // Drive the outputs from the half registers.
    always_comb begin
        acc_lo_o = cur[0];
        acc_hi_o = cur[1];
    end
endmodule

// File: rtl/mac_sat_acc_chk.sv
// Property checker for mac_sat_acc, attached by bind below.
// Assumes: the synchronous active-low reset of the checked block.
module mac_sat_acc_chk #(
    parameter int HALF_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              sat_mode_i,
    input logic              hi_load_en_i,
    input logic [HALF_W-1:0] hi_load_data_i,
    input logic              lo_load_en_i,
    input logic [HALF_W-1:0] lo_load_data_i,
    input logic [HALF_W-1:0] acc_hi_o,
    input logic [HALF_W-1:0] acc_lo_o
);
    localparam logic [HALF_W-1:0] POS_LIMIT = {1'b0, {(HALF_W-1){1'b1}}};
    localparam logic [HALF_W-1:0] NEG_LIMIT = {1'b1, {(HALF_W-1){1'b0}}};

    // R8: idle cycles keep both halves
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !hi_load_en_i && !lo_load_en_i) |=> ($stable(acc_hi_o) && $stable(acc_lo_o)));

    // R9: a load lands in its half
    a_r9_lo_load: assert property (@(posedge clk) disable iff (!rst_n)
        lo_load_en_i |=> (acc_lo_o == $past(lo_load_data_i)));

    a_r9_hi_load: assert property (@(posedge clk) disable iff (!rst_n)
        hi_load_en_i |=> (acc_hi_o == $past(hi_load_data_i)));

    // R7: saturating accumulate keeps upper high bits and never clears the flag
    a_r7_hi_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && sat_mode_i && !hi_load_en_i) |=>
            (acc_hi_o[HALF_W-1:1] == $past(acc_hi_o[HALF_W-1:1]) && (acc_hi_o[0] || !$past(acc_hi_o[0]))));

    // R5/R6: when the flag rises, the low half sits at a limit
    a_r5_r6_clamp_on_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && sat_mode_i && !hi_load_en_i && !lo_load_en_i) |=>
            (!$rose(acc_hi_o[0]) || acc_lo_o == POS_LIMIT || acc_lo_o == NEG_LIMIT));
endmodule

bind mac_sat_acc mac_sat_acc_chk #(.HALF_W(HALF_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .sat_mode_i     (sat_mode_i),
    .hi_load_en_i   (hi_load_en_i),
    .hi_load_data_i (hi_load_data_i),
    .lo_load_en_i   (lo_load_en_i),
    .lo_load_data_i (lo_load_data_i),
    .acc_hi_o       (acc_hi_o),
    .acc_lo_o       (acc_lo_o)
);

// File: tb/mac_sat_acc_bench.sv
// Bench for mac_sat_acc: a vector table walked by one loop, then directed reset, hold and priority tests.
module mac_sat_acc_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;
    localparam int NVEC       = 13;

    // Vector fields: sat(1) op_a(16) op_b(16) init_hi(32) init_lo(32) exp_hi(32) exp_lo(32)
    localparam logic [160:0] VECS [NVEC] = '{
        {1'b0, 16'h0003, 16'h0004, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_000C}, // R3 basic
        {1'b0, 16'hFFFF, 16'h0001, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF}, // R3 sign-extend
        {1'b0, 16'h0002, 16'h0003, 32'h0000_0000, 32'hFFFF_FFFE, 32'h0000_0001, 32'h0000_0004}, // R3 carry
        {1'b0, 16'h8000, 16'h8000, 32'h0000_0005, 32'h0000_0000, 32'h0000_0005, 32'h4000_0000}, // R2 min*min
        {1'b0, 16'h8000, 16'h7FFF, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'hC000_8000}, // R2 min*max
        {1'b1, 16'h0064, 16'h0064, 32'hABCD_0000, 32'h0000_0005, 32'hABCD_0000, 32'h0000_2715}, // R4 in range
        {1'b1, 16'h8000, 16'h8000, 32'h0000_0000, 32'h7FFF_0000, 32'h0000_0001, 32'h7FFF_FFFF}, // R5 pos clamp
        {1'b1, 16'h8000, 16'h7FFF, 32'h1234_5670, 32'h8000_0010, 32'h1234_5671, 32'h8000_0000}, // R6 neg clamp
        {1'b1, 16'hFFFF, 16'h0001, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF}, // R4 no borrow
        {1'b1, 16'h8000, 16'h8000, 32'h0000_0000, 32'h3FFF_FFFF, 32'h0000_0000, 32'h7FFF_FFFF}, // R4 exact max
        {1'b1, 16'h0001, 16'h0001, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h7FFF_FFFF}, // R7 flag already set
        {1'b1, 16'hFFFF, 16'h0001, 32'h0000_0000, 32'h8000_0001, 32'h0000_0000, 32'h8000_0000}, // R6 exact min
        {1'b1, 16'h0001, 16'h0001, 32'h0000_0001, 32'h0000_0000, 32'h0000_0001, 32'h0000_0001}  // R7 flag sticky
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] op_a_i = '0;
    logic [15:0] op_b_i = '0;
    logic        sat_mode_i = 1'b0;
    logic        hi_load_en_i = 1'b0;
    logic [31:0] hi_load_data_i = '0;
    logic        lo_load_en_i = 1'b0;
    logic [31:0] lo_load_data_i = '0;
    logic [31:0] acc_hi_o;
    logic [31:0] acc_lo_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_sat_acc u_mac_sat_acc (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .op_a_i         (op_a_i),
        .op_b_i         (op_b_i),
        .sat_mode_i     (sat_mode_i),
        .hi_load_en_i   (hi_load_en_i),
        .hi_load_data_i (hi_load_data_i),
        .lo_load_en_i   (lo_load_en_i),
        .lo_load_data_i (lo_load_data_i),
        .acc_hi_o       (acc_hi_o),
        .acc_lo_o       (acc_lo_o)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] exp_hi, input logic [31:0] exp_lo);
        checks++;
        if (acc_hi_o !== exp_hi || acc_lo_o !== exp_lo) begin
            errors++;
            $display("FAIL %s: got hi=%h lo=%h expected hi=%h lo=%h", req, acc_hi_o, acc_lo_o, exp_hi, exp_lo);
        end
    endtask

    task automatic load_both(input logic [31:0] hi, input logic [31:0] lo);
        hi_load_en_i = 1'b1; hi_load_data_i = hi;
        lo_load_en_i = 1'b1; lo_load_data_i = lo;
        tick();
        hi_load_en_i = 1'b0; lo_load_en_i = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        start_i = 1'b1; op_a_i = 16'h0005; op_b_i = 16'h0005; // start under reset must be ignored
        tick();
        check("R1 reset", 32'h0, 32'h0);
        start_i = 1'b0;
        rst_n = 1'b1;
        tick();

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            load_both(VECS[i][127:96], VECS[i][95:64]);
            sat_mode_i = VECS[i][160];
            op_a_i = VECS[i][159:144];
            op_b_i = VECS[i][143:128];
            start_i = 1'b1;
            tick();
            start_i = 1'b0;
            check($sformatf("R2-R7 vector %0d", i), VECS[i][63:32], VECS[i][31:0]);
        end

        // R8: idle cycles with changing operands and mode
        load_both(32'h0101_0202, 32'h0303_0404);
        for (int k = 0; k < 4; k++) begin
            sat_mode_i = k[0];
            op_a_i = 16'h7FFF - 16'(k);
            op_b_i = 16'h8000 + 16'(k);
            tick();
        end
        check("R8 idle hold", 32'h0101_0202, 32'h0303_0404);

        // R9: low load with accumulate; high still takes the 64-bit sum
        load_both(32'h0000_0000, 32'hFFFF_FFFF);
        sat_mode_i = 1'b0; op_a_i = 16'h0001; op_b_i = 16'h0001;
        start_i = 1'b1; lo_load_en_i = 1'b1; lo_load_data_i = 32'hDEAD_BEEF;
        tick();
        start_i = 1'b0; lo_load_en_i = 1'b0;
        check("R9 lo load priority", 32'h0000_0001, 32'hDEAD_BEEF);

        // R9: high load with saturating overflow; low still clamps
        load_both(32'h0000_0000, 32'h7FFF_FFFF);
        sat_mode_i = 1'b1; op_a_i = 16'h0001; op_b_i = 16'h0001;
        start_i = 1'b1; hi_load_en_i = 1'b1; hi_load_data_i = 32'h5555_AAAA;
        tick();
        start_i = 1'b0; hi_load_en_i = 1'b0;
        check("R9 hi load priority", 32'h5555_AAAA, 32'h7FFF_FFFF);

        // R3: back-to-back accumulations
        load_both(32'h0, 32'h0);
        sat_mode_i = 1'b0; op_a_i = 16'h8000; op_b_i = 16'h8000; start_i = 1'b1;
        tick(); tick(); tick(); tick();
        start_i = 1'b0;
        check("R3 four accumulations", 32'h0000_0001, 32'h0000_0000);

        // R1: reset in mid-run with a load pending
        rst_n = 1'b0; hi_load_en_i = 1'b1; hi_load_data_i = 32'h1; start_i = 1'b1;
        tick();
        check("R1 mid-run reset", 32'h0, 32'h0);
        rst_n = 1'b1; hi_load_en_i = 1'b0; start_i = 1'b0;
        tick();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule